// File: doc/BRIEF.md
# Short Inter-Packet Gap Rate Limiter

This block sits in a GMII transmit path and decides, once per packet, whether that packet may leave with a shortened inter-packet gap or must use the normal one. The host raises a short-gap request, and software-controlled enables gate it. When the limit is switched on, the number of short-gap packets is capped. After every short-gap packet a hold-off counter is loaded and counts down on the wire-side clock. No further short gap is granted until the counter is empty. With the default count of 10,000 this gives about one short gap per 100 ppm of clocks.

The decision is taken on the start-of-packet strobe and is held as the gap selection until the next strobe. The MAC reads that selection when it builds the gap in front of the packet. The limit applies only in GMII mode. On any other interface mode the counter is held empty and requests pass with no rate limit. The same is true whenever limiting is off, so turning the limit back on never delays the first grant.

Top module: `short_gap_limiter`

## Requirements
- R1: After reset, `short_gap_o` is 0 (normal gap) and `holdoff_cnt_o` is 0.
- R2: At a start-of-packet strobe, `short_gap_o` becomes 1 on the following clock only if `short_gap_en_i` and `gap_req_i` are both 1 (and the hold-off allows it); otherwise it becomes 0.
- R3: `short_gap_o` changes only on a clock where `sop_i` is 1. Changes of request or enables between strobes do not affect the packet in flight.
- R4: When limiting is active (`limit_en_i`, `short_gap_en_i` and `gmii_mode_i` all 1), a granted short gap loads `holdoff_cnt_o` with HOLDOFF_CNT on the clock of the strobe.
- R5: While limiting is active and the counter is nonzero, it decreases by exactly one on each clock. It stops at 0, never wraps, and never exceeds HOLDOFF_CNT.
- R6: A strobe seen while limiting is active and the counter is nonzero gives a normal gap (`short_gap_o` = 0) and does not reload the counter.
- R7: A strobe on the first clock at which the counter reads 0 may be granted a short gap.
- R8: With `gmii_mode_i` = 0 the limit has no effect. The counter is held at 0, and back-to-back short-gap requests are all granted.
- R9: Whenever limiting is not active, the counter is forced to 0 on the next clock. This includes clearing a hold-off already in progress, so a grant right after re-enabling is not delayed.
- R10: With `short_gap_en_i` = 0, no short gap is granted and the counter is not loaded, whatever `limit_en_i` and `gap_req_i` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Wire-side transmit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gap_req_i | input | 1 | Host request for a short gap on the next packet |
| short_gap_en_i | input | 1 | Enables short-gap transmission |
| limit_en_i | input | 1 | Enables the short-gap rate limit |
| gmii_mode_i | input | 1 | 1 = GMII interface (limit applies), 0 = other interface |
| sop_i | input | 1 | Start-of-packet strobe, one clock per packet |
| short_gap_o | output | 1 | Gap selection for the current packet: 1 short, 0 normal |
| holdoff_cnt_o | output | CNT_W | Remaining hold-off clocks |

## Verification
The bench builds the block with HOLDOFF_CNT = 12 and CNT_W = 4. This keeps a full hold-off cycle, from load through each decrement down to saturation at zero, within a few dozen clocks. Each step can then be compared against a counted expectation. It also places the exact boundary cases within reach: the last nonzero count when a request is refused, and the first zero count when a request is granted. The hold-off can also be cut short by dropping the enable, by dropping the GMII mode, or by switching to non-GMII mode. Chains of back-to-back strobes run through the vector table with the counter carried from one row to the next.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
  typedef enum logic {
    GAP_NORMAL = 1'b0,
    GAP_SHORT  = 1'b1
  } gap_sel_e;
endpackage

// File: rtl/sgl_limit_ctrl.sv
module sgl_limit_ctrl (
  input  logic gap_req_i,
  input  logic short_gap_en_i,
  input  logic limit_en_i,
  input  logic gmii_mode_i,
  input  logic cnt_zero_i,
  output logic limit_act_o,
  output logic grant_ok_o
);
  // limit only meaningful on GMII with short gap enabled
  assign limit_act_o = limit_en_i & short_gap_en_i & gmii_mode_i;
  assign grant_ok_o  = short_gap_en_i & gap_req_i & (~limit_act_o | cnt_zero_i);
endmodule

// File: rtl/sgl_holdoff_cnt.sv
module sgl_holdoff_cnt #(
  parameter int HOLDOFF_CNT = 10000,
  parameter int CNT_W       = $clog2(HOLDOFF_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             limit_act_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] LoadVal = CNT_W'(HOLDOFF_CNT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!limit_act_i)        cnt_d = '0;
    else if (load_i)         cnt_d = LoadVal;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sgl_gap_grant.sv
module sgl_gap_grant
  import sgl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sop_i,
  input  logic     grant_ok_i,
  output gap_sel_e gap_sel_o
);
  gap_sel_e sel_q;

  // decision latched per packet, held until next strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sel_q <= GAP_NORMAL;
    else if (sop_i) sel_q <= grant_ok_i ? GAP_SHORT : GAP_NORMAL;
  end

  assign gap_sel_o = sel_q;
endmodule

// File: rtl/short_gap_limiter.sv
module short_gap_limiter
  import sgl_pkg::*;
#(
  parameter int HOLDOFF_CNT = 10000,
  parameter int CNT_W       = $clog2(HOLDOFF_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gap_req_i,
  input  logic             short_gap_en_i,
  input  logic             limit_en_i,
  input  logic             gmii_mode_i,
  input  logic             sop_i,
  output logic             short_gap_o,
  output logic [CNT_W-1:0] holdoff_cnt_o
);
  logic     limit_act, grant_ok, cnt_zero, load;
  gap_sel_e gap_sel;

  sgl_limit_ctrl u_ctrl (
    .gap_req_i      (gap_req_i),
    .short_gap_en_i (short_gap_en_i),
    .limit_en_i     (limit_en_i),
    .gmii_mode_i    (gmii_mode_i),
    .cnt_zero_i     (cnt_zero),
    .limit_act_o    (limit_act),
    .grant_ok_o     (grant_ok)
  );

  assign load = sop_i & grant_ok & limit_act;

  sgl_holdoff_cnt #(
    .HOLDOFF_CNT (HOLDOFF_CNT),
    .CNT_W       (CNT_W)
  ) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .limit_act_i (limit_act),
    .load_i      (load),
    .cnt_o       (holdoff_cnt_o),
    .zero_o      (cnt_zero)
  );

  sgl_gap_grant u_grant (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sop_i      (sop_i),
    .grant_ok_i (grant_ok),
    .gap_sel_o  (gap_sel)
  );

  assign short_gap_o = (gap_sel == GAP_SHORT);
endmodule

// File: rtl/short_gap_limiter_chk.sv
module short_gap_limiter_chk #(
  parameter int HOLDOFF_CNT = 10000,
  parameter int CNT_W       = $clog2(HOLDOFF_CNT + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gap_req_i,
  input logic             short_gap_en_i,
  input logic             limit_en_i,
  input logic             gmii_mode_i,
  input logic             sop_i,
  input logic             short_gap_o,
  input logic [CNT_W-1:0] holdoff_cnt_o
);
  logic lim_on;
  assign lim_on = limit_en_i & short_gap_en_i & gmii_mode_i;

  assert_deny_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_i && !(short_gap_en_i && gap_req_i) |=> !short_gap_o);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sop_i |=> $stable(short_gap_o));

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_on && sop_i && gap_req_i && holdoff_cnt_o == '0
    |=> holdoff_cnt_o == CNT_W'(HOLDOFF_CNT));

  assert_decrement_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim_on && holdoff_cnt_o != '0 |=> holdoff_cnt_o == $past(holdoff_cnt_o) - 1'b1);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holdoff_cnt_o <= CNT_W'(HOLDOFF_CNT));

  assert_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_i && lim_on && holdoff_cnt_o != '0 |=> !short_gap_o);

  assert_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lim_on |=> holdoff_cnt_o == '0);
endmodule

bind short_gap_limiter short_gap_limiter_chk #(
  .HOLDOFF_CNT (HOLDOFF_CNT),
  .CNT_W       (CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .gap_req_i      (gap_req_i),
  .short_gap_en_i (short_gap_en_i),
  .limit_en_i     (limit_en_i),
  .gmii_mode_i    (gmii_mode_i),
  .sop_i          (sop_i),
  .short_gap_o    (short_gap_o),
  .holdoff_cnt_o  (holdoff_cnt_o)
);

// File: tb/short_gap_limiter_bench.sv
module short_gap_limiter_bench;
  localparam int H  = 12;
  localparam int CW = $clog2(H + 1);

  typedef struct packed {
    logic       en;
    logic       lim;
    logic       gmii;
    logic       req;
    logic       exp_g;
    logic [7:0] exp_c;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0},     // R2 enable off
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0},     // R2 no request
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd0},     // R2 grant
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd0},     // R2 back-to-back unlimited
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0},     // R10 limit without enable
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0},     // R8 non-GMII
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0},     // R8 non-GMII again
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'(H)},    // R4 load
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'(H-1)},  // R6 blocked
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'(H-2)},  // R5 counting
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 8'd0},     // R9 limit off clears
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'(H)},    // R9 immediate grant on re-enable
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0}      // R8 leaving GMII clears
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, en = 1'b0, lim = 1'b0, gmii = 1'b0, sop = 1'b0;
  logic          sg;
  logic [CW-1:0] cnt;
  int errors = 0, checks = 0;

  always #2ns clk = ~clk;

  short_gap_limiter #(.HOLDOFF_CNT(H), .CNT_W(CW)) u_short_gap_limiter (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .gap_req_i      (req),
    .short_gap_en_i (en),
    .limit_en_i     (lim),
    .gmii_mode_i    (gmii),
    .sop_i          (sop),
    .short_gap_o    (sg),
    .holdoff_cnt_o  (cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setin(input logic e, input logic l, input logic g, input logic r, input logic s);
    en = e; lim = l; gmii = g; req = r; sop = s;
  endtask

  initial begin
    #400us;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 grant at reset", int'(sg), 0);
    chk("R1 count at reset", int'(cnt), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 grant after release", int'(sg), 0);

    // table: one strobe per clock, counter state carried row to row
    for (int i = 0; i < NV; i++) begin
      setin(VECS[i].en, VECS[i].lim, VECS[i].gmii, VECS[i].req, 1'b1);
      tick();
      chk($sformatf("R2/R4/R6/R8/R9/R10 row %0d grant", i), int'(sg), int'(VECS[i].exp_g));
      chk($sformatf("R4/R5/R8/R9 row %0d count", i), int'(cnt), int'(VECS[i].exp_c));
    end
    setin(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    tick();

    // R3: grant held while inputs change between strobes
    setin(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    tick();
    chk("R3 grant taken", int'(sg), 1);
    setin(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R3 grant held mid-packet", int'(sg), 1);
    end
    setin(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    tick();
    chk("R3 no strobe, selection unchanged", int'(sg), 1);
    setin(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    tick();
    chk("R3 next strobe takes new decision", int'(sg), 0);

    // R5/R6/R7: full hold-off walk
    setin(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    tick();
    chk("R4 loaded", int'(cnt), H);
    sop = 1'b0;
    for (int k = 1; k < H; k++) begin
      tick();
      chk("R5 decrement", int'(cnt), H - k);
    end
    // count is 1: last refused strobe
    sop = 1'b1;
    tick();
    chk("R6 refused at count 1", int'(sg), 0);
    chk("R6 no reload, reaches zero", int'(cnt), 0);
    // first zero count: granted
    tick();
    chk("R7 granted at first zero", int'(sg), 1);
    chk("R7 reload", int'(cnt), H);
    sop = 1'b0; req = 1'b0;
    repeat (H) tick();
    chk("R5 reached zero", int'(cnt), 0);
    repeat (3) tick();
    chk("R5 saturates at zero", int'(cnt), 0);

    // R9: drop limit mid hold-off
    setin(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    tick();
    sop = 1'b0;
    repeat (3) tick();
    chk("R9 hold-off running", int'(cnt), H - 3);
    lim = 1'b0;
    tick();
    chk("R9 cleared by limit off", int'(cnt), 0);
    lim = 1'b1; sop = 1'b1;
    tick();
    chk("R9 grant right after re-enable", int'(sg), 1);
    // R10: enable off during hold-off also clears, and denies
    setin(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    tick();
    chk("R10 no grant without enable", int'(sg), 0);
    chk("R10 counter not loaded", int'(cnt), 0);

    // R8: consecutive grants on non-GMII with limit on
    setin(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 non-GMII grant", int'(sg), 1);
      chk("R8 non-GMII count", int'(cnt), 0);
    end
    sop = 1'b0;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule